// File: doc/BRIEF.md
# Flash Request Dispatcher

The dispatcher takes one decoded flash-channel request at a time and carries it through to a single completion. A request gives a kind (read, write, erase, counter-set, counter-get), a tag, an address, a length or erase size code and, for kinds that carry data, a payload word. The block checks the request against the read-length limit, the erase code range and the counter-get payload limit. It asks an external protection checker whether the address span may be touched. It then starts one back-end flash operation and waits for that operation to report done.

Every accepted request gets exactly one completion, and that completion echoes the request tag. A refused length, a protection refusal, a back-end error or an unknown kind all lead to the same response: an unsuccessful completion without data. Reads and counter-get operations that succeed report data of the request length. Writes, erases and counter-set operations that succeed report no data. Completion framing, flash storage and the protection tables belong to neighbouring blocks.

Top module: `flash_req_dispatcher`

## Requirements
- R1: `req_ready` is high only while no request is in flight. After an accepted request (`req_valid` and `req_ready` at a clock edge) it stays low until the completion is handed off (`cpl_valid` and `cpl_ready` at an edge), and it is high again in the following cycle.
- R2: Each accepted request yields exactly one completion whose `cpl_tag` equals the request tag. While `cpl_ready` is low, `cpl_valid`, `cpl_tag` and `cpl_success` hold.
- R3: Kind code 2 is erase. Its length field is a size code: 0 gives a span of 4096 bytes, 1 gives 32768, 2 gives 65536 and 3 gives 131072, and that span appears on `be_len` and `prot_span`. A code of 4 or more is refused with no protection query and no back-end start.
- R4: Write (kind 1) and erase requests with valid lengths query protection with `prot_is_write`=1 and the byte span, before any back-end start. A denial produces an unsuccessful completion and no back-end start.
- R5: A successful write, erase or counter-set (kind 3) completes with `cpl_success`=1, `cpl_with_data`=0 and `cpl_len`=0.
- R6: The read (kind 0) limit is 32 shifted left by an effective size. The effective size is `cfg_req_size`, but when that exceeds `cfg_sup_size` the supported value is used instead, and a supported value of 0 is then taken as 1. A read longer than the limit is refused with no query and no start.
- R7: A read within the limit queries protection with `prot_is_write`=0. If it is not denied and the back-end reports no error, it completes with `cpl_success`=1, `cpl_with_data`=1 and `cpl_len` equal to the request length.
- R8: A counter-get (kind 4) whose length exceeds `TX_LIMIT` (default 64) is refused. Otherwise it starts the back-end without a protection query and completes with data of the request length.
- R9: A back-end error (`be_error` with `be_done`) turns the completion into an unsuccessful one without data.
- R10: The payload register behind `be_data` loads `req_data` only when a write or counter-set request is accepted. Other kinds leave it unchanged.
- R11: Kind codes 5 to 7 are refused with an unsuccessful completion, no protection query and no back-end start.
- R12: `be_start` is a one-cycle pulse. During it, `be_op` equals the request kind and `be_addr` equals the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Dispatcher idle, request accepted on this edge |
| req_kind | input | 3 | Request kind code |
| req_tag | input | TAG_W | Request tag |
| req_addr | input | ADDR_W | Flash address |
| req_len | input | LEN_W | Byte length, or size code for erase |
| req_data | input | DATA_W | Payload word for write and counter-set |
| cfg_req_size | input | 3 | Requested read-size field |
| cfg_sup_size | input | 3 | Supported read-size field |
| prot_query | output | 1 | Protection check request (one cycle) |
| prot_is_write | output | 1 | Query is for write access |
| prot_addr | output | ADDR_W | Queried address |
| prot_span | output | SPAN_W | Queried byte span |
| prot_tag | output | TAG_W | Tag of the requester |
| prot_deny | input | 1 | Same-cycle answer: access refused |
| be_start | output | 1 | Back-end operation start pulse |
| be_op | output | 3 | Back-end operation code (equals kind) |
| be_addr | output | ADDR_W | Back-end address |
| be_len | output | SPAN_W | Back-end byte count |
| be_data | output | DATA_W | Captured payload |
| be_done | input | 1 | Back-end operation finished |
| be_error | input | 1 | Back-end failed, valid with be_done |
| cpl_valid | output | 1 | Completion present |
| cpl_ready | input | 1 | Completion taken |
| cpl_success | output | 1 | Successful completion |
| cpl_with_data | output | 1 | Completion carries data |
| cpl_tag | output | TAG_W | Echoed tag |
| cpl_len | output | LEN_W | Data length, zero without data |

## Verification
A corrupted sequencer state shows up within a few cycles as a second `be_start` pulse, a missing completion or `req_ready` rising while a completion is still pending. A stale request register shows up at the completion as a wrong `cpl_tag` or `cpl_len`, or at the start pulse as a wrong `be_len`. The table-driven walk covers every kind against denial, back-end error and each size boundary. Each check looks at the first start pulse and the first completion after acceptance, so extra or lost events are detected on the request that caused them.

// File: rtl/flash_disp_pkg.sv
package flash_disp_pkg;

    localparam int KIND_W = 3;

    localparam logic [KIND_W-1:0] K_READ    = 3'd0;
    localparam logic [KIND_W-1:0] K_WRITE   = 3'd1;
    localparam logic [KIND_W-1:0] K_ERASE   = 3'd2;
    localparam logic [KIND_W-1:0] K_CTR_SET = 3'd3;
    localparam logic [KIND_W-1:0] K_CTR_GET = 3'd4;

    localparam int unsigned ERASE_BASE = 32'd4096;
    localparam int unsigned READ_UNIT  = 32'd32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_START,
        ST_WAIT,
        ST_CPL
    } seq_state_e;

    typedef struct packed {
        logic refuse;
        logic need_prot;
        logic for_write;
    } chk_res_t;

    function automatic int unsigned erase_span(input logic [1:0] code);
        int unsigned sh;
        sh = (code == 2'd0) ? 0 : (32'(code) + 2);
        return ERASE_BASE << sh;
    endfunction

    function automatic int unsigned read_limit(input logic [2:0] want, input logic [2:0] sup);
        logic [2:0] eff;
        eff = want;
        if (want > sup) eff = (sup == 3'd0) ? 3'd1 : sup;
        return READ_UNIT << eff;
    endfunction

    function automatic logic carries_payload(input logic [KIND_W-1:0] k);
        return (k == K_WRITE) || (k == K_CTR_SET);
    endfunction

    function automatic logic returns_data(input logic [KIND_W-1:0] k);
        return (k == K_READ) || (k == K_CTR_GET);
    endfunction

endpackage

// File: rtl/fd_req_check.sv
module fd_req_check
    import flash_disp_pkg::*;
#(
    parameter int LEN_W    = 13,
    parameter int SPAN_W   = 18,
    parameter int TX_LIMIT = 64
) (
    input  logic [KIND_W-1:0] kind,
    input  logic [LEN_W-1:0]  len,
    input  logic [2:0]        want_size,
    input  logic [2:0]        sup_size,
    output logic [SPAN_W-1:0] op_len,
    output chk_res_t          res
);
    localparam int unsigned CODE_LIMIT = 4;

    always_comb begin
        op_len = SPAN_W'(len);
        res    = '{refuse: 1'b0, need_prot: 1'b0, for_write: 1'b0};
        case (kind)
            K_READ: begin
                res.refuse    = 32'(len) > read_limit(want_size, sup_size);
                res.need_prot = 1'b1;
            end
            K_WRITE: begin
                res.need_prot = 1'b1;
                res.for_write = 1'b1;
            end
            K_ERASE: begin
                res.refuse    = 32'(len) >= CODE_LIMIT;
                res.need_prot = 1'b1;
                res.for_write = 1'b1;
                op_len        = res.refuse ? '0 : SPAN_W'(erase_span(len[1:0]));
            end
            K_CTR_SET: ;
            K_CTR_GET: res.refuse = 32'(len) > 32'(TX_LIMIT);
            default:   res.refuse = 1'b1;
        endcase
    end
endmodule

// File: rtl/fd_seq.sv
module fd_seq
    import flash_disp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  chk_res_t chk,
    input  logic     prot_deny,
    input  logic     be_done,
    input  logic     be_error,
    input  logic     cpl_ready,
    output logic     req_ready,
    output logic     load,
    output logic     prot_query,
    output logic     be_start,
    output logic     cpl_valid,
    output logic     failed
);
    seq_state_e state_q, state_d;
    logic       fail_q, fail_d;

    always_comb begin
        state_d = state_q;
        fail_d  = fail_q;
        case (state_q)
            ST_IDLE: if (req_valid) begin
                state_d = ST_CHECK;
                fail_d  = 1'b0;
            end
            ST_CHECK: begin
                if (chk.refuse || (chk.need_prot && prot_deny)) begin
                    fail_d  = 1'b1;
                    state_d = ST_CPL;
                end else begin
                    state_d = ST_START;
                end
            end
            ST_START: state_d = ST_WAIT;
            ST_WAIT: if (be_done) begin
                fail_d  = be_error;
                state_d = ST_CPL;
            end
            ST_CPL: if (cpl_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            fail_q  <= fail_d;
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign load       = req_ready && req_valid;
    assign prot_query = (state_q == ST_CHECK) && chk.need_prot && !chk.refuse;
    assign be_start   = (state_q == ST_START);
    assign cpl_valid  = (state_q == ST_CPL);
    assign failed     = fail_q;
endmodule

// File: rtl/flash_req_dispatcher.sv
module flash_req_dispatcher
    import flash_disp_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 13,
    parameter int SPAN_W   = 18,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 32,
    parameter int TX_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_data,
    input  logic [2:0]        cfg_req_size,
    input  logic [2:0]        cfg_sup_size,
    output logic              prot_query,
    output logic              prot_is_write,
    output logic [ADDR_W-1:0] prot_addr,
    output logic [SPAN_W-1:0] prot_span,
    output logic [TAG_W-1:0]  prot_tag,
    input  logic              prot_deny,
    output logic              be_start,
    output logic [2:0]        be_op,
    output logic [ADDR_W-1:0] be_addr,
    output logic [SPAN_W-1:0] be_len,
    output logic [DATA_W-1:0] be_data,
    input  logic              be_done,
    input  logic              be_error,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic              cpl_success,
    output logic              cpl_with_data,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic [LEN_W-1:0]  cpl_len
);
    logic [KIND_W-1:0] kind_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [DATA_W-1:0] pay_q;
    logic [SPAN_W-1:0] op_len;
    chk_res_t          chk;
    logic              load, failed;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= '0;
            tag_q  <= '0;
            addr_q <= '0;
            len_q  <= '0;
            pay_q  <= '0;
        end else if (load) begin
            kind_q <= req_kind;
            tag_q  <= req_tag;
            addr_q <= req_addr;
            len_q  <= req_len;
            if (carries_payload(req_kind)) pay_q <= req_data;
        end
    end

    fd_req_check #(
        .LEN_W   (LEN_W),
        .SPAN_W  (SPAN_W),
        .TX_LIMIT(TX_LIMIT)
    ) u_check (
        .kind     (kind_q),
        .len      (len_q),
        .want_size(cfg_req_size),
        .sup_size (cfg_sup_size),
        .op_len   (op_len),
        .res      (chk)
    );

    fd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .chk       (chk),
        .prot_deny (prot_deny),
        .be_done   (be_done),
        .be_error  (be_error),
        .cpl_ready (cpl_ready),
        .req_ready (req_ready),
        .load      (load),
        .prot_query(prot_query),
        .be_start  (be_start),
        .cpl_valid (cpl_valid),
        .failed    (failed)
    );

    assign prot_is_write = chk.for_write;
    assign prot_addr     = addr_q;
    assign prot_span     = op_len;
    assign prot_tag      = tag_q;

    assign be_op   = kind_q;
    assign be_addr = addr_q;
    assign be_len  = op_len;
    assign be_data = pay_q;

    assign cpl_success   = !failed;
    assign cpl_with_data = !failed && returns_data(kind_q);
    assign cpl_tag       = tag_q;
    assign cpl_len       = cpl_with_data ? len_q : '0;
endmodule

// File: rtl/fd_checker.sv
module fd_checker #(
    parameter int TAG_W  = 4,
    parameter int SPAN_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              prot_query,
    input logic              prot_deny,
    input logic              be_start,
    input logic [2:0]        be_op,
    input logic [SPAN_W-1:0] be_len,
    input logic              cpl_valid,
    input logic              cpl_ready,
    input logic              cpl_success,
    input logic              cpl_with_data,
    input logic [TAG_W-1:0]  cpl_tag
);
    AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(req_ready && cpl_valid)); // R1
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_CPL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_tag) && $stable(cpl_success))); // R2
    AST_DENY_NO_START: assert property (@(posedge clk) disable iff (rst)
        (prot_query && prot_deny) |=> (!be_start && cpl_valid && !cpl_success)); // R4
    AST_ERASE_SPAN_POW2: assert property (@(posedge clk) disable iff (rst)
        (be_start && be_op == 3'd2) |-> ($countones(be_len) == 1 && be_len >= SPAN_W'(4096))); // R3
    AST_FAIL_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !cpl_success) |-> !cpl_with_data); // R9
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        be_start |=> !be_start); // R12
endmodule

bind flash_req_dispatcher fd_checker #(
    .TAG_W (TAG_W),
    .SPAN_W(SPAN_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .prot_query   (prot_query),
    .prot_deny    (prot_deny),
    .be_start     (be_start),
    .be_op        (be_op),
    .be_len       (be_len),
    .cpl_valid    (cpl_valid),
    .cpl_ready    (cpl_ready),
    .cpl_success  (cpl_success),
    .cpl_with_data(cpl_with_data),
    .cpl_tag      (cpl_tag)
);

// File: tb/flash_req_dispatcher_tb.sv
module flash_req_dispatcher_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [3:0]  req_tag = '0;
    logic [31:0] req_addr = '0;
    logic [12:0] req_len = '0;
    logic [31:0] req_data = '0;
    logic [2:0]  cfg_req_size = '0;
    logic [2:0]  cfg_sup_size = '0;
    logic        prot_query, prot_is_write;
    logic [31:0] prot_addr;
    logic [17:0] prot_span;
    logic [3:0]  prot_tag;
    logic        prot_deny;
    logic        be_start;
    logic [2:0]  be_op;
    logic [31:0] be_addr;
    logic [17:0] be_len;
    logic [31:0] be_data;
    logic        be_done = 1'b0, be_error = 1'b0;
    logic        cpl_valid, cpl_ready = 1'b1;
    logic        cpl_success, cpl_with_data;
    logic [3:0]  cpl_tag;
    logic [12:0] cpl_len;

    logic deny_cfg = 1'b0, err_cfg = 1'b0;
    int   errors = 0, checks = 0;
    bit   done_flag = 1'b0;

    always #2.5 clk = ~clk;
    assign prot_deny = prot_query & deny_cfg;

    flash_req_dispatcher u_dut (.*);

    typedef struct packed {
        logic [2:0]  typ;
        logic [3:0]  tag;
        logic [12:0] len;
        logic [2:0]  rs;
        logic [2:0]  sup;
        logic        deny;
        logic        err;
        logic        ex_start;
        logic        ex_q;
        logic        ex_wr;
        logic        ex_ok;
        logic        ex_data;
        logic [17:0] ex_len;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 4'd3,  13'd16,  3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'd16},
        '{3'd2, 4'd5,  13'd0,   3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'd4096},
        '{3'd2, 4'd6,  13'd1,   3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'd32768},
        '{3'd2, 4'd7,  13'd2,   3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'd65536},
        '{3'd2, 4'd8,  13'd3,   3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 18'd131072},
        '{3'd2, 4'd9,  13'd4,   3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'd0},
        '{3'd2, 4'd10, 13'd1,   3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 18'd32768},
        '{3'd1, 4'd11, 13'd8,   3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 18'd8},
        '{3'd1, 4'd12, 13'd8,   3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'd8},
        '{3'd0, 4'd1,  13'd64,  3'd1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 18'd64},
        '{3'd0, 4'd2,  13'd65,  3'd1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'd65},
        '{3'd0, 4'd3,  13'd128, 3'd3, 3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 18'd128},
        '{3'd0, 4'd4,  13'd129, 3'd3, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'd129},
        '{3'd0, 4'd5,  13'd64,  3'd2, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 18'd64},
        '{3'd0, 4'd6,  13'd65,  3'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'd65},
        '{3'd0, 4'd7,  13'd32,  3'd1, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 18'd32},
        '{3'd3, 4'd13, 13'd8,   3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 18'd8},
        '{3'd4, 4'd14, 13'd64,  3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 18'd64},
        '{3'd4, 4'd15, 13'd65,  3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'd65},
        '{3'd6, 4'd0,  13'd4,   3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 18'd4},
        '{3'd4, 4'd2,  13'd16,  3'd0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'd16}
    };

    int          n_start, n_query;
    logic        s_qwr;
    logic [17:0] s_span, s_len;
    logic [2:0]  s_op;
    logic [31:0] s_addr, s_data;
    logic        got_cpl, c_ok, c_data;
    logic [3:0]  c_tag;
    logic [12:0] c_len;

    task automatic check(input bit cond, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin : backend_stub
        forever begin
            @(negedge clk);
            if (be_start) begin
                repeat (2) @(negedge clk);
                be_done  = 1'b1;
                be_error = err_cfg;
                @(negedge clk);
                be_done  = 1'b0;
                be_error = 1'b0;
            end
        end
    end

    task automatic issue(input logic [2:0] k, input logic [3:0] t, input logic [12:0] l,
                         input logic [31:0] a, input logic [31:0] d);
        n_start = 0; n_query = 0; got_cpl = 1'b0;
        s_qwr = 1'b0; s_span = '0; s_len = '0; s_op = '0; s_addr = '0; s_data = '0;
        c_ok = 1'b0; c_data = 1'b0; c_tag = '0; c_len = '0;
        @(negedge clk);
        req_kind = k; req_tag = t; req_len = l; req_addr = a; req_data = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R1", "ready low after accept", req_ready, 0);
        for (int i = 0; i < 40; i++) begin
            if (prot_query) begin
                n_query++; s_qwr = prot_is_write; s_span = prot_span;
            end
            if (be_start) begin
                n_start++; s_op = be_op; s_len = be_len; s_addr = be_addr; s_data = be_data;
            end
            if (cpl_valid) begin
                got_cpl = 1'b1; c_ok = cpl_success; c_data = cpl_with_data;
                c_tag = cpl_tag; c_len = cpl_len;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        check(req_ready == 1'b1 && cpl_valid == 1'b0, "R1", "idle after handoff", req_ready, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        check(cpl_valid == 1'b0 && be_start == 1'b0, "R2", "reset no cpl/start", cpl_valid, 0);

        for (int v = 0; v < NV; v++) begin
            vec_t e;
            logic [31:0] a;
            e = VECS[v];
            a = 32'h0010_0000 + 32'(v) * 32'h100;
            cfg_req_size = e.rs; cfg_sup_size = e.sup;
            deny_cfg = e.deny; err_cfg = e.err;
            issue(e.typ, e.tag, e.len, a, 32'hA000 + 32'(v));
            check(got_cpl, "R2", $sformatf("vec%0d completion seen", v), got_cpl, 1);
            check(c_tag == e.tag, "R2", $sformatf("vec%0d tag", v), c_tag, e.tag);
            check(n_start == (e.ex_start ? 1 : 0), "R3 R4 R6 R11", $sformatf("vec%0d starts", v),
                  n_start, e.ex_start);
            check(n_query == (e.ex_q ? 1 : 0), "R4 R7 R8", $sformatf("vec%0d queries", v),
                  n_query, e.ex_q);
            if (e.ex_q) begin
                check(s_qwr == e.ex_wr, "R4 R7", $sformatf("vec%0d is_write", v), s_qwr, e.ex_wr);
                check(s_span == e.ex_len, "R3 R4", $sformatf("vec%0d span", v), s_span, e.ex_len);
            end
            if (e.ex_start) begin
                check(s_len == e.ex_len, "R3", $sformatf("vec%0d be_len", v), s_len, e.ex_len);
                check(s_op == e.typ, "R12", $sformatf("vec%0d be_op", v), s_op, e.typ);
                check(s_addr == a, "R12", $sformatf("vec%0d be_addr", v), s_addr, a);
            end
            check(c_ok == e.ex_ok, "R5 R9", $sformatf("vec%0d success", v), c_ok, e.ex_ok);
            check(c_data == e.ex_data, "R7 R8", $sformatf("vec%0d with_data", v), c_data, e.ex_data);
            check(c_len == (e.ex_data ? e.len : 13'd0), "R5 R7", $sformatf("vec%0d cpl_len", v),
                  c_len, e.ex_data ? e.len : 0);
        end

        // R2: completion held under back-pressure
        deny_cfg = 1'b0; err_cfg = 1'b0; cfg_req_size = 3'd1; cfg_sup_size = 3'd3;
        cpl_ready = 1'b0;
        @(negedge clk);
        req_kind = 3'd3; req_tag = 4'd9; req_len = 13'd4; req_addr = 32'h40; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 40 && !cpl_valid; i++) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(cpl_valid && cpl_tag == 4'd9 && cpl_success, "R2", "held completion", cpl_tag, 9);
            check(req_ready == 1'b0, "R1", "busy while completion pending", req_ready, 0);
        end
        cpl_ready = 1'b1;
        @(negedge clk);
        check(cpl_valid == 1'b0 && req_ready == 1'b1, "R2", "single completion", cpl_valid, 0);

        // R10: payload capture only for write and counter-set
        issue(3'd1, 4'd1, 13'd4, 32'h100, 32'h1111_AAAA);
        check(s_data == 32'h1111_AAAA, "R10", "write payload", s_data, 32'h1111_AAAA);
        issue(3'd0, 4'd2, 13'd4, 32'h200, 32'h2222_BBBB);
        check(s_data == 32'h1111_AAAA, "R10", "read keeps payload", s_data, 32'h1111_AAAA);
        issue(3'd3, 4'd3, 13'd4, 32'h300, 32'h3333_CCCC);
        check(s_data == 32'h3333_CCCC, "R10", "counter-set payload", s_data, 32'h3333_CCCC);
        issue(3'd2, 4'd4, 13'd0, 32'h400, 32'h4444_DDDD);
        check(s_data == 32'h3333_CCCC, "R10", "erase keeps payload", s_data, 32'h3333_CCCC);

        // R9: late back-end error on erase
        err_cfg = 1'b1;
        issue(3'd2, 4'd6, 13'd3, 32'h500, 32'h0);
        check(n_start == 1 && !c_ok && !c_data && c_tag == 4'd6, "R9", "erase error", c_ok, 0);
        err_cfg = 1'b0;

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule